// File: doc/BRIEF.md
# Bias DAC Command Router

This block sits on a video board and listens to a shared serial command stream from the timing controller. Each command is a 24-bit word framed by an active-high frame line and clocked in on the rising edge of a serial clock. All three serial inputs are asynchronous to the system clock and are brought in through a synchronizer. A word that is complete, carries the video-board type code and names this board's jumper address is turned into a 16-bit command. That command is shifted out to one of two four-channel bias DAC devices, and each device has its own clock, data and load lines.

The block also drives the enable of the analog switches that connect the bias voltages to the sensor. That enable is a synchronized copy of a control line from the timing board. Any word that fails a test is dropped with no activity on either DAC interface, so several boards and clock-driver cards can share the same stream.

The serial stream has no back-pressure; the sender cannot be stalled. The input serial clock must stay high and low for at least three system clocks each. At that rate a full input word takes longer than one output shift, so a decoded command never arrives while the shifter it targets is still busy.

Top module: `dac_word_router`

## Requirements
- R1: Only a frame in which exactly 24 rising serial-clock edges occur while the frame line is high produces a DAC write. A frame with fewer or more edges produces no activity on either DAC interface.
- R2: Word bits 23:20 hold a board address. A word produces a write only when this field equals the 4-bit jumper input.
- R3: A word produces a write only when bits 19 and 18 are both 1. Any other value in these bits marks a clock-driver command, which leaves both DAC interfaces idle.
- R4: Word bit 16 selects the device: 0 writes DAC interface 0 and 1 writes DAC interface 1. The other interface stays idle, and bit 17 has no effect.
- R5: The outgoing word is 16 bits, sent MSB first: word bits 15:14 as channel select, then two 0 bits, then word bits 11:0. There are exactly 16 rising edges on that DAC clock, and the data line changes only while the DAC clock is low.
- R6: After the 16th bit, the load line of the written device pulses high for exactly one system clock. At most one load line is high at a time.
- R7: The bias enable output equals the bias control input delayed by two system clocks, so the switches close only when the control line is high.
- R8: While reset is low, every DAC clock, data and load output and the bias enable are 0.
- R9: Input data are taken MSB first on the rising serial-clock edge, and the frame line is active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ssi_clk_i | input | 1 | Serial command clock, asynchronous |
| ssi_data_i | input | 1 | Serial command data, MSB first |
| ssi_frame_i | input | 1 | Serial frame, high for the whole word |
| board_jmp_i | input | 4 | Board address from the jumpers (fitted reads 0) |
| bias_ctl_i | input | 1 | Bias switch control from the timing board |
| dac_sclk_o | output | 2 | Serial clock per DAC device |
| dac_sdata_o | output | 2 | Serial data per DAC device |
| dac_load_o | output | 2 | Load strobe per DAC device |
| bias_en_o | output | 1 | Bias output switch enable |

## Verification
Two functions can run at the same time. One DAC shifter can be serializing a command while the receiver is taking in the next word, and the bias enable can change while that shift is under way. The bench provokes this by sending two frames back to back, one for each device. While the first command is still shifting out, it raises the bias control. It then checks that the enable follows after two clocks, and that each device receives exactly one intact 16-bit word with a single load pulse.

// File: rtl/dac_router_pkg.sv
package dac_router_pkg;
  localparam int IN_W     = 24;
  localparam int BRD_W    = 4;
  localparam int BRD_LSB  = 20;
  localparam int TYPE_MSB = 19;
  localparam int TYPE_LSB = 18;
  localparam int DEV_LSB  = 16;
  localparam int CH_LSB   = 14;
  localparam int CH_W     = 2;
  localparam int VAL_W    = 12;
  localparam int OUT_W    = 16;
  localparam int NUM_DEV  = 2;
  localparam int PAD_W    = OUT_W - CH_W - VAL_W;

  function automatic logic [OUT_W-1:0] pack_out(input logic [IN_W-1:0] w);
    return {w[CH_LSB +: CH_W], {PAD_W{1'b0}}, w[VAL_W-1:0]};
  endfunction
endpackage

// File: rtl/ssi_word_rx.sv
module ssi_word_rx
  import dac_router_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sclk_i,
  input  logic            sdata_i,
  input  logic            frame_i,
  output logic            word_vld_o,
  output logic [IN_W-1:0] word_o
);
  localparam int CNT_W = $clog2(IN_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(IN_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(IN_W + 1);

  logic [SYNC:0]     sclk_p, frm_p;
  logic [SYNC-1:0]   dat_p;
  logic [IN_W-1:0]   sh;
  logic [CNT_W-1:0]  cnt;
  logic              rise, fon, fend;

  assign rise = sclk_p[SYNC-1] & ~sclk_p[SYNC];
  assign fon  = frm_p[SYNC-1];
  assign fend = ~frm_p[SYNC-1] & frm_p[SYNC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sclk_p     <= '0;
      frm_p      <= '0;
      dat_p      <= '0;
      sh         <= '0;
      cnt        <= '0;
      word_vld_o <= 1'b0;
      word_o     <= '0;
    end else begin
      sclk_p     <= {sclk_p[SYNC-1:0], sclk_i};
      frm_p      <= {frm_p[SYNC-1:0], frame_i};
      dat_p      <= {dat_p[SYNC-2:0], sdata_i};
      word_vld_o <= 1'b0;
      if (fend) begin
        word_vld_o <= (cnt == CNT_FULL);
        word_o     <= sh;
        cnt        <= '0;
      end else if (fon && rise) begin
        sh <= {sh[IN_W-2:0], dat_p[SYNC-1]};
        if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
      end
    end
  end

  p_vld_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |=> !word_vld_o);
  p_cnt_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_OVER);
endmodule

// File: rtl/dac_field_decode.sv
module dac_field_decode
  import dac_router_pkg::*;
(
  input  logic               word_vld_i,
  input  logic [IN_W-1:0]    word_i,
  input  logic [BRD_W-1:0]   board_i,
  output logic [NUM_DEV-1:0] start_o,
  output logic [OUT_W-1:0]   out_word_o
);
  localparam int DSEL_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1;

  logic              is_video, is_mine, hit;
  logic [DSEL_W-1:0] dsel;
  logic              unused_bits;

  assign is_video    = &word_i[TYPE_MSB:TYPE_LSB];
  assign is_mine     = (word_i[BRD_LSB +: BRD_W] == board_i);
  assign hit         = word_vld_i & is_video & is_mine;
  assign dsel        = word_i[DEV_LSB +: DSEL_W];
  assign out_word_o  = pack_out(word_i);
  assign unused_bits = ^{word_i[DEV_LSB+1], word_i[CH_LSB-1:VAL_W]};

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_sel
    assign start_o[d] = hit && (dsel == DSEL_W'(d));
  end
endmodule

// File: rtl/dac_word_tx.sv
module dac_word_tx
  import dac_router_pkg::*;
#(
  parameter int HALF_CYC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [OUT_W-1:0] word_i,
  output logic             sclk_o,
  output logic             sdata_o,
  output logic             load_o
);
  localparam int DIV_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int BIT_W = $clog2(OUT_W);
  localparam logic [DIV_W-1:0] DIV_END = DIV_W'(HALF_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_END = BIT_W'(OUT_W - 1);

  logic             busy, ph;
  logic [OUT_W-1:0] sh;
  logic [BIT_W-1:0] bits;
  logic [DIV_W-1:0] div;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      ph     <= 1'b0;
      sh     <= '0;
      bits   <= '0;
      div    <= '0;
      load_o <= 1'b0;
    end else begin
      load_o <= 1'b0;
      if (!busy) begin
        if (start_i) begin
          busy <= 1'b1;
          sh   <= word_i;
          bits <= '0;
          ph   <= 1'b0;
          div  <= '0;
        end
      end else if (div != DIV_END) begin
        div <= div + 1'b1;
      end else begin
        div <= '0;
        if (!ph) begin
          ph <= 1'b1;
        end else begin
          ph <= 1'b0;
          sh <= {sh[OUT_W-2:0], 1'b0};
          if (bits == BIT_END) begin
            busy   <= 1'b0;
            load_o <= 1'b1;
          end else begin
            bits <= bits + 1'b1;
          end
        end
      end
    end
  end

  assign sclk_o  = ph;
  assign sdata_o = busy & sh[OUT_W-1];

  p_data_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> $stable(sdata_o));
  p_load_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |=> !load_o);
  p_load_after_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_o |-> $past(sclk_o));
endmodule

// File: rtl/dac_word_router.sv
module dac_word_router
  import dac_router_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HALF_CYC    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ssi_clk_i,
  input  logic               ssi_data_i,
  input  logic               ssi_frame_i,
  input  logic [BRD_W-1:0]   board_jmp_i,
  input  logic               bias_ctl_i,
  output logic [NUM_DEV-1:0] dac_sclk_o,
  output logic [NUM_DEV-1:0] dac_sdata_o,
  output logic [NUM_DEV-1:0] dac_load_o,
  output logic               bias_en_o
);
  logic               word_vld;
  logic [IN_W-1:0]    word;
  logic [NUM_DEV-1:0] start;
  logic [OUT_W-1:0]   out_word;
  logic [1:0]         bias_s;

  ssi_word_rx #(.SYNC(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .sclk_i(ssi_clk_i), .sdata_i(ssi_data_i), .frame_i(ssi_frame_i),
    .word_vld_o(word_vld), .word_o(word)
  );

  dac_field_decode u_dec (
    .word_vld_i(word_vld), .word_i(word), .board_i(board_jmp_i),
    .start_o(start), .out_word_o(out_word)
  );

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_tx
    dac_word_tx #(.HALF_CYC(HALF_CYC)) u_tx (
      .clk(clk), .rst_n(rst_n),
      .start_i(start[d]), .word_i(out_word),
      .sclk_o(dac_sclk_o[d]), .sdata_o(dac_sdata_o[d]), .load_o(dac_load_o[d])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bias_s <= '0;
    else        bias_s <= {bias_s[0], bias_ctl_i};
  end
  assign bias_en_o = bias_s[1];

  p_one_dev_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start));
  p_one_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dac_load_o));
  p_bias_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bias_en_o |-> $past(bias_ctl_i, 2));
endmodule

// File: tb/dac_word_router_tb.sv
module dac_word_router_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       s_clk = 1'b0, s_dat = 1'b0, s_frm = 1'b0;
  logic [3:0] jmp = 4'h5;
  logic       ctl = 1'b0;
  logic [1:0] d_sclk, d_sdat, d_load;
  logic       bias;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dac_word_router u_dut (
    .clk(clk), .rst_n(rst_n),
    .ssi_clk_i(s_clk), .ssi_data_i(s_dat), .ssi_frame_i(s_frm),
    .board_jmp_i(jmp), .bias_ctl_i(ctl),
    .dac_sclk_o(d_sclk), .dac_sdata_o(d_sdat), .dac_load_o(d_load),
    .bias_en_o(bias)
  );

  // monitor of both DAC interfaces
  logic        mon_clr = 1'b0;
  logic [1:0]  prev_sclk = 2'b00;
  logic [15:0] cap [2];
  int          nbits [2];
  int          nloads [2];

  always @(negedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (mon_clr) begin
        cap[d] <= '0; nbits[d] <= 0; nloads[d] <= 0;
      end else begin
        if (d_sclk[d] && !prev_sclk[d]) begin
          cap[d]   <= {cap[d][14:0], d_sdat[d]};
          nbits[d] <= nbits[d] + 1;
        end
        if (d_load[d]) nloads[d] <= nloads[d] + 1;
      end
    end
    prev_sclk <= d_sclk;
  end

  // {word24, nbits5, jumper4, expected device (3 = none) 2, expected word16}
  localparam logic [50:0] VEC [10] = '{
    {24'h5C3ABC, 5'd24, 4'h5, 2'd0, 16'h0ABC},
    {24'h5DC123, 5'd24, 4'h5, 2'd1, 16'hC123},
    {24'h5E4FFF, 5'd24, 4'h5, 2'd0, 16'h4FFF},
    {24'h5F8000, 5'd24, 4'h5, 2'd1, 16'h8000},
    {24'h581234, 5'd24, 4'h5, 2'd3, 16'h0000},
    {24'h541234, 5'd24, 4'h5, 2'd3, 16'h0000},
    {24'h6C0123, 5'd24, 4'h5, 2'd3, 16'h0000},
    {24'hAC2777, 5'd24, 4'hA, 2'd0, 16'h0777},
    {24'h5C0555, 5'd20, 4'h5, 2'd3, 16'h0000},
    {24'h5C0555, 5'd25, 4'h5, 2'd3, 16'h0000}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R4 R5 R6 R9";
      1, 3: return "R4 R5";
      2: return "R4 (bit 17 ignored) R5";
      4, 5: return "R3";
      6, 7: return "R2";
      default: return "R1";
    endcase
  endfunction

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    @(negedge clk); #1 mon_clr = 1'b1;
    @(negedge clk); #1 mon_clr = 1'b0;
  endtask

  task automatic send_frame(input logic [23:0] w, input int n);
    s_frm = 1'b1;
    wait_clk(3);
    for (int i = 0; i < n; i++) begin
      s_clk = 1'b0;
      s_dat = (i < 24) ? w[23-i] : 1'b0;
      wait_clk(3);
      s_clk = 1'b1;
      wait_clk(3);
    end
    s_clk = 1'b0;
    wait_clk(3);
    s_frm = 1'b0;
    wait_clk(3);
  endtask

  task automatic check_dev(input int d, input int exp_dev, input logic [15:0] exp_w,
                           input string tag);
    if (exp_dev == d) begin
      check(nloads[d] == 1, tag, $sformatf("dev%0d load pulses", d), nloads[d], 1);
      check(nbits[d] == 16 && cap[d] == exp_w, tag, $sformatf("dev%0d word", d),
            cap[d], exp_w);
    end else begin
      check(nloads[d] == 0 && nbits[d] == 0, tag, $sformatf("dev%0d idle edges", d),
            nbits[d] + nloads[d], 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    ctl = 1'b1;
    wait_clk(5);
    // R8: reset state, with control held high
    check(d_sclk == 0 && d_sdat == 0 && d_load == 0, "R8", "dac outputs in reset",
          {d_sclk, d_sdat, d_load}, 0);
    check(bias == 1'b0, "R8", "bias enable in reset", bias, 0);
    ctl = 1'b0;
    rst_n = 1'b1;
    wait_clk(4);
    clear_mon();

    // R7: two-clock latency of the bias enable
    ctl = 1'b1;
    wait_clk(1);
    check(bias == 1'b0, "R7", "bias one clock after rise", bias, 0);
    wait_clk(1);
    check(bias == 1'b1, "R7", "bias two clocks after rise", bias, 1);
    ctl = 1'b0;
    wait_clk(2);
    check(bias == 1'b0, "R7", "bias two clocks after fall", bias, 0);

    for (int i = 0; i < 10; i++) begin
      jmp = VEC[i][21:18];
      clear_mon();
      send_frame(VEC[i][50:27], int'(VEC[i][26:22]));
      wait_clk(120);
      for (int d = 0; d < 2; d++)
        check_dev(d, int'(VEC[i][17:16]), VEC[i][15:0], vec_tag(i));
    end

    // R4 R5 R6 R7: back-to-back frames while bias toggles during a shift
    jmp = 4'h5;
    clear_mon();
    send_frame(24'h5C0321, 24);
    fork
      send_frame(24'h5D4ABC, 24);
      begin
        wait_clk(20);
        ctl = 1'b1;
        wait_clk(2);
        check(bias == 1'b1, "R7", "bias during dac shift", bias, 1);
      end
    join
    wait_clk(120);
    check_dev(0, 0, 16'h0321, "R4 R5 R6 overlap");
    check_dev(1, 1, 16'h4ABC, "R4 R5 R6 overlap");
    ctl = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule